// File: doc/BRIEF.md
# Dual-Channel Storage Controller Register Block

This block is the memory-mapped register file of a two-channel serial storage host controller. It sits behind a 512-byte window reached through a simple request port: a valid strobe, a write flag, a byte address, an access size and 32-bit write data. Read data comes back through a registered return path. Each channel has a bus-master DMA command byte, a DMA status byte, a 32-bit descriptor address and a small software-data byte. Each channel also has a configuration/status word, a serial control word, a serial status word and an interrupt-enable field. Two packed status words show the DMA command, DMA status and pending-interrupt state of both channels in one read.

The two channel interrupt levels are captured into the configuration/status words, and their OR drives a single level interrupt. A write to a serial control word with its low bit set gives that channel's device bus a one-cycle reset pulse. Both pulses are held high while the controller itself is in reset. Accesses to the two task-file windows are not decoded locally. They are passed to an external port with the channel and the local offset, and that port's read data is returned as the result.

Data is right-aligned and little-endian. Byte k of an access of N bytes at address A belongs to address A+k and travels in data bits 8k+7:8k. Size code 0 is a byte, 1 is a 16-bit half-word, and 2 or 3 is a 32-bit word.

Top module: `dual_chan_regblk`

## Requirements
- R1: A read request returns its data on `rd_data` with `rd_valid` high in the cycle after the request edge. `rd_valid` is low after any cycle without a read request.
- R2: Channel 0 DMA bytes are at 0x00 (command), 0x01 (software data), 0x02 (status), 0x03 (always zero) and 0x04..0x07 (descriptor address, little-endian). Channel 1 uses the same layout at 0x08..0x0F. Reads of unmapped offsets return zero, and writes to them change nothing.
- R3: Writes to 0x10, 0x11 and 0x12 act as writes to 0x00, 0x01 and 0x02. Writes to 0x18, 0x19 and 0x1A act as writes to 0x08, 0x09 and 0x0A.
- R4: A read at 0x10 returns the following, ORed together: channel 0 command in bits 7:0, bit 4 when channel 0 has a pending interrupt, bit 6 when channel 1 has a pending interrupt, bit 14 equal to channel 1 status bit 2, channel 0 status in bits 23:16 and channel 1 status in bits 31:24.
- R5: A read at 0x18 returns the following, ORed together: channel 1 command in bits 7:0, bit 4 for channel 1's pending interrupt, and channel 1 status in bits 23:16.
- R6: The software-data byte keeps only the low 6 bits of a write and reads back 0 in bits 7:6.
- R7: The serial control words (0x100 channel 0, 0x180 channel 1) store bits 11:0 of a 32-bit write. Such a write with bit 0 set drives that channel's `bus_reset` bit high for exactly the next cycle. Writes to these words of any other size are ignored.
- R8: The interrupt-enable fields (0x148, 0x1C8) store write bits 31:16 ANDed with 0x3EED, only on 32-bit writes. They read back in bits 31:16 with zero below.
- R9: The serial status words (0x104, 0x184) read 0x113 when that channel's `dev_present` is high, and 0 otherwise.
- R10: The configuration/status words (0xA0, 0xE0) read 0x65150000 after reset. Their bit 11 is the channel interrupt input as sampled at the previous clock edge.
- R11: `irq_out` is high exactly when bit 11 of either configuration/status word is set, so it follows the OR of the inputs one cycle later. Both `bus_reset` bits are high while `rst_n` is low.
- R12: Accesses at 0x80..0x87 and 0x8A (channel 0) and at 0xC0..0xC7 and 0xCA (channel 1) drive `tf_valid` in the same cycle, with `tf_chan`, `tf_offset` = address bits 3:0, size and write data. Reads there return `tf_rdata`, masked to the size.
- R13: DMA status bit 0 equals bit 0 of the last command written. Writing 1 to bit 1 or bit 2 clears it. Bits 7:3 store the written value. A rising edge of the channel interrupt input sets bit 2, and this set wins over a clear in the same cycle.
- R14: A byte or half-word write changes only the addressed bytes. Read data is masked to the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address in the window |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_wdata | input | 32 | Right-aligned write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| chan_irq_in | input | 2 | Per-channel interrupt level |
| dev_present | input | 2 | Per-channel device attached |
| irq_out | output | 1 | Combined level interrupt |
| bus_reset | output | 2 | Per-channel device bus reset pulse |
| tf_valid | output | 1 | Task-file access strobe |
| tf_write | output | 1 | Task-file write flag |
| tf_chan | output | 1 | Task-file channel |
| tf_offset | output | 4 | Task-file local offset |
| tf_size | output | 2 | Task-file access size |
| tf_wdata | output | 32 | Task-file write data |
| tf_rdata | input | 32 | Task-file read data (same cycle) |

## Verification
Stored registers can only be seen by reading them back. A wrong mask, alias or byte lane therefore shows up in `rd_data` one cycle after the read that follows the corrupting write. The bench reads back right after each write, so the fault cannot hide behind later traffic. State tied to the interrupt path shows up sooner. A wrong captured level appears on `irq_out` and in the packed status words one edge after the input changes. A lost or stuck reset request appears on `bus_reset` in the cycle right after the control write. Task-file decode errors appear on the forwarding outputs during the request cycle itself.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int ADDR_W   = 9;
  localparam int DATA_W   = 32;
  localparam int NCH      = 2;
  localparam int BYTES_W  = DATA_W / 8;
  localparam int SCTL_W   = 12;
  localparam int IEN_W    = 16;
  localparam int SW_W     = 6;
  localparam logic [IEN_W-1:0]  IEN_MASK = 16'h3EED;
  localparam logic [15:0]       CS_ID    = 16'h6515;
  localparam logic [DATA_W-1:0] SSTAT_ON = 32'h0000_0113;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} acc_size_e;

  // number of bytes carried by an access
  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // new status byte after a register write: 7:3 stored, 2:1 write-one-clear, 0 kept
  function automatic logic [7:0] status_wr(logic [7:0] old, logic [7:0] d);
    return {d[7:3], old[2] & ~d[2], old[1] & ~d[1], old[0]};
  endfunction

  function automatic logic [DATA_W-1:0] combo_both(logic [7:0] cmd0, logic [7:0] st0,
                                                   logic [7:0] st1, logic p0, logic p1);
    logic [DATA_W-1:0] v;
    v = {st1, st0, 8'h00, cmd0};
    v[4]  = v[4] | p0;
    v[6]  = v[6] | p1;
    v[14] = st1[2];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] combo_one(logic [7:0] cmd1, logic [7:0] st1, logic p1);
    logic [DATA_W-1:0] v;
    v = {8'h00, st1, 8'h00, cmd1};
    v[4] = v[4] | p1;
    return v;
  endfunction

  // one byte of a channel's DMA block by lane
  function automatic logic [7:0] dma_byte(logic [2:0] lane, logic [7:0] cmd, logic [SW_W-1:0] sw,
                                          logic [7:0] st, logic [31:0] adr);
    case (lane)
      3'd0:    return cmd;
      3'd1:    return {{(8-SW_W){1'b0}}, sw};
      3'd2:    return st;
      3'd4:    return adr[7:0];
      3'd5:    return adr[15:8];
      3'd6:    return adr[23:16];
      3'd7:    return adr[31:24];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dcr_wr_decode.sv
module dcr_wr_decode
  import dcr_pkg::*;
(
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NCH-1:0]              cmd_we,
  output logic [NCH-1:0][7:0]         cmd_d,
  output logic [NCH-1:0]              sw_we,
  output logic [NCH-1:0][7:0]         sw_d,
  output logic [NCH-1:0]              st_we,
  output logic [NCH-1:0][7:0]         st_d,
  output logic [NCH-1:0][BYTES_W-1:0] adr_be,
  output logic [NCH-1:0][DATA_W-1:0]  adr_d,
  output logic [NCH-1:0]              sctl_we,
  output logic [NCH-1:0]              ien_we
);
  logic [2:0] nbytes;
  logic       is_word;
  assign nbytes  = size_bytes(size);
  assign is_word = (nbytes == 3'd4);

  // per-byte decode of the DMA region 0x00..0x1F (aliases at 0x10..0x1A)
  always_comb begin : byte_dec
    logic [ADDR_W-1:0] a;
    logic [7:0]        b;
    logic              ch;
    logic [2:0]        lane;
    cmd_we = '0; cmd_d = '0; sw_we = '0; sw_d = '0;
    st_we  = '0; st_d  = '0; adr_be = '0; adr_d = '0;
    for (int k = 0; k < BYTES_W; k++) begin
      a    = addr + ADDR_W'(k);
      b    = wdata[8*k +: 8];
      ch   = a[3];
      lane = a[2:0];
      if (wr_en && (3'(k) < nbytes) && (a[ADDR_W-1:5] == '0)) begin
        if (!a[4] || lane < 3'd3) begin
          case (lane)
            3'd0: begin cmd_we[ch] = 1'b1; cmd_d[ch] = b; end
            3'd1: begin sw_we[ch]  = 1'b1; sw_d[ch]  = b; end
            3'd2: begin st_we[ch]  = 1'b1; st_d[ch]  = b; end
            3'd4, 3'd5, 3'd6, 3'd7: begin
              adr_be[ch][lane[1:0]]        = 1'b1;
              adr_d[ch][8*lane[1:0] +: 8]  = b;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // serial control / interrupt enable: exact address, 32-bit writes only
  assign sctl_we[0] = wr_en && is_word && (addr == 9'h100);
  assign sctl_we[1] = wr_en && is_word && (addr == 9'h180);
  assign ien_we[0]  = wr_en && is_word && (addr == 9'h148);
  assign ien_we[1]  = wr_en && is_word && (addr == 9'h1C8);
endmodule

// File: rtl/dcr_dma_chan.sv
module dcr_dma_chan
  import dcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [7:0]         cmd_d,
  input  logic               sw_we,
  input  logic [SW_W-1:0]    sw_d,
  input  logic               st_we,
  input  logic [7:0]         st_d,
  input  logic [BYTES_W-1:0] adr_be,
  input  logic [DATA_W-1:0]  adr_d,
  input  logic               irq_rise,
  output logic [7:0]         cmd_q,
  output logic [SW_W-1:0]    sw_q,
  output logic [7:0]         status,
  output logic [DATA_W-1:0]  adr_q
);
  logic [4:0] st_hi_q;
  logic       st_int_q, st_err_q, st_act_q;
  logic [7:0] st_next;

  assign status  = {st_hi_q, st_int_q, st_err_q, st_act_q};
  assign st_next = status_wr(status, st_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      sw_q     <= '0;
      st_hi_q  <= '0;
      st_err_q <= 1'b0;
      st_int_q <= 1'b0;
      st_act_q <= 1'b0;
    end else begin
      if (cmd_we) begin
        cmd_q    <= cmd_d;
        st_act_q <= cmd_d[0];
      end
      if (sw_we) sw_q <= sw_d;
      if (st_we) begin
        st_hi_q  <= st_next[7:3];
        st_err_q <= st_next[1];
      end
      // a new interrupt edge wins over a same-cycle clear
      st_int_q <= irq_rise | (st_we ? st_next[2] : st_int_q);
    end
  end

  for (genvar i = 0; i < BYTES_W; i++) begin : g_adr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         adr_q[8*i +: 8] <= '0;
      else if (adr_be[i]) adr_q[8*i +: 8] <= adr_d[8*i +: 8];
    end
  end

  assert_int_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_d[2] && !irq_rise) |=> !status[2]);
  assert_int_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> status[2]);
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(cmd_q));
endmodule

// File: rtl/dcr_link_chan.sv
module dcr_link_chan
  import dcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_lvl,
  input  logic              sctl_we,
  input  logic [SCTL_W-1:0] sctl_d,
  input  logic              ien_we,
  input  logic [IEN_W-1:0]  ien_d,
  output logic [DATA_W-1:0] cs_word,
  output logic [SCTL_W-1:0] sctl_q,
  output logic [IEN_W-1:0]  ien_q,
  output logic              irq_pend,
  output logic              irq_rise,
  output logic              bus_rst
);
  logic reset_req;
  assign reset_req = sctl_we & sctl_d[0];
  assign irq_rise  = irq_lvl & ~irq_pend;
  assign cs_word   = {CS_ID, 4'b0000, irq_pend, 11'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend <= 1'b0;
      sctl_q   <= '0;
      ien_q    <= '0;
      bus_rst  <= 1'b1;
    end else begin
      irq_pend <= irq_lvl;
      bus_rst  <= reset_req;
      if (sctl_we) sctl_q <= sctl_d;
      if (ien_we)  ien_q  <= ien_d & IEN_MASK;
    end
  end

  assert_bus_reset_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> bus_rst);
  assert_bus_reset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_req |=> !bus_rst);
  assert_ien_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_we |=> $stable(ien_q));
  assert_pend_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl |=> irq_pend);
endmodule

// File: rtl/dual_chan_regblk.sv
module dual_chan_regblk
  import dcr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  input  logic [NCH-1:0]       chan_irq_in,
  input  logic [NCH-1:0]       dev_present,
  output logic                 irq_out,
  output logic [NCH-1:0]       bus_reset,
  output logic                 tf_valid,
  output logic                 tf_write,
  output logic                 tf_chan,
  output logic [3:0]           tf_offset,
  output logic [1:0]           tf_size,
  output logic [DATA_W-1:0]    tf_wdata,
  input  logic [DATA_W-1:0]    tf_rdata
);
  logic                        wr_en, rd_en, tf_hit;
  logic [NCH-1:0]              cmd_we, sw_we, st_we, sctl_we, ien_we;
  logic [NCH-1:0][7:0]         cmd_d, sw_d, st_d;
  logic [NCH-1:0][BYTES_W-1:0] adr_be;
  logic [NCH-1:0][DATA_W-1:0]  adr_d;
  logic [NCH-1:0][7:0]         cmd_q, st_q;
  logic [NCH-1:0][SW_W-1:0]    sw_q;
  logic [NCH-1:0][DATA_W-1:0]  adr_q, cs_w;
  logic [NCH-1:0][SCTL_W-1:0]  sctl_w;
  logic [NCH-1:0][IEN_W-1:0]   ien_w;
  logic [NCH-1:0]              irq_pend, irq_rise;
  logic [DATA_W-1:0]           rd_mux;

  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  // task-file windows: data 0x?0..0x?7 and control 0x?A, channel in bit 6
  assign tf_hit    = (req_addr[8:7] == 2'b01) &&
                     ((req_addr[5:3] == 3'b000) || (req_addr[5:0] == 6'h0A));
  assign tf_valid  = req_valid & tf_hit;
  assign tf_write  = req_write;
  assign tf_chan   = req_addr[6];
  assign tf_offset = req_addr[3:0];
  assign tf_size   = req_size;
  assign tf_wdata  = req_wdata;

  dcr_wr_decode u_dec (
    .wr_en  (wr_en),
    .addr   (req_addr),
    .size   (req_size),
    .wdata  (req_wdata),
    .cmd_we (cmd_we),
    .cmd_d  (cmd_d),
    .sw_we  (sw_we),
    .sw_d   (sw_d),
    .st_we  (st_we),
    .st_d   (st_d),
    .adr_be (adr_be),
    .adr_d  (adr_d),
    .sctl_we(sctl_we),
    .ien_we (ien_we)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [7:0] sw_full;
    assign sw_full = sw_d[g];

    dcr_dma_chan u_dma (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_we  (cmd_we[g]),
      .cmd_d   (cmd_d[g]),
      .sw_we   (sw_we[g]),
      .sw_d    (sw_full[SW_W-1:0]),
      .st_we   (st_we[g]),
      .st_d    (st_d[g]),
      .adr_be  (adr_be[g]),
      .adr_d   (adr_d[g]),
      .irq_rise(irq_rise[g]),
      .cmd_q   (cmd_q[g]),
      .sw_q    (sw_q[g]),
      .status  (st_q[g]),
      .adr_q   (adr_q[g])
    );

    dcr_link_chan u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_lvl (chan_irq_in[g]),
      .sctl_we (sctl_we[g]),
      .sctl_d  (req_wdata[SCTL_W-1:0]),
      .ien_we  (ien_we[g]),
      .ien_d   (req_wdata[DATA_W-1:DATA_W-IEN_W]),
      .cs_word (cs_w[g]),
      .sctl_q  (sctl_w[g]),
      .ien_q   (ien_w[g]),
      .irq_pend(irq_pend[g]),
      .irq_rise(irq_rise[g]),
      .bus_rst (bus_reset[g])
    );
  end

  assign irq_out = |irq_pend;

  // read multiplexer
  always_comb begin : rd_sel
    logic [4:0] ab;
    rd_mux = '0;
    if (req_addr[ADDR_W-1:4] == '0) begin
      for (int k = 0; k < BYTES_W; k++) begin
        ab = {1'b0, req_addr[3:0]} + 5'(k);
        if (!ab[4])
          rd_mux[8*k +: 8] = dma_byte(ab[2:0], cmd_q[ab[3]], sw_q[ab[3]], st_q[ab[3]], adr_q[ab[3]]);
      end
    end else begin
      case (req_addr)
        9'h010: rd_mux = combo_both(cmd_q[0], st_q[0], st_q[1], irq_pend[0], irq_pend[1]);
        9'h018: rd_mux = combo_one(cmd_q[1], st_q[1], irq_pend[1]);
        9'h0A0: rd_mux = cs_w[0];
        9'h0E0: rd_mux = cs_w[1];
        9'h100: rd_mux = {{(DATA_W-SCTL_W){1'b0}}, sctl_w[0]};
        9'h180: rd_mux = {{(DATA_W-SCTL_W){1'b0}}, sctl_w[1]};
        9'h104: rd_mux = dev_present[0] ? SSTAT_ON : '0;
        9'h184: rd_mux = dev_present[1] ? SSTAT_ON : '0;
        9'h148: rd_mux = {ien_w[0], {(DATA_W-IEN_W){1'b0}}};
        9'h1C8: rd_mux = {ien_w[1], {(DATA_W-IEN_W){1'b0}}};
        default: if (tf_hit) rd_mux = tf_rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux & size_mask(req_size);
    end
  end

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_read_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_irq_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq_in != '0) |=> irq_out);
  assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq_in == '0) |=> !irq_out);
  assert_tf_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !tf_valid);
endmodule

// File: tb/dual_chan_regblk_tb.sv
module dual_chan_regblk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [1:0]  chan_irq_in = '0, dev_present = '0;
  logic        irq_out;
  logic [1:0]  bus_reset;
  logic        tf_valid, tf_write, tf_chan;
  logic [3:0]  tf_offset;
  logic [1:0]  tf_size;
  logic [31:0] tf_wdata, tf_rdata;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign tf_rdata = {16'hC0DE, 8'h00, 3'b000, tf_chan, tf_offset};

  dual_chan_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .chan_irq_in(chan_irq_in),
    .dev_present(dev_present), .irq_out(irq_out), .bus_reset(bus_reset),
    .tf_valid(tf_valid), .tf_write(tf_write), .tf_chan(tf_chan),
    .tf_offset(tf_offset), .tf_size(tf_size), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
  );

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(string req, logic [8:0] a, logic [1:0] sz, logic [31:0] exp);
    logic [31:0] v;
    rd(a, sz, v);
    check(req, $sformatf("read %h", a), v, exp);
  endtask

  task automatic t_reset();
    check("R11", "bus_reset in reset", {30'b0, bus_reset}, 32'h3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11", "bus_reset after reset", {30'b0, bus_reset}, 32'h0);
    check("R11", "irq_out after reset", {31'b0, irq_out}, 32'h0);
    rd_chk("R10", 9'h0A0, 2'd2, 32'h6515_0000);
    rd_chk("R10", 9'h0E0, 2'd2, 32'h6515_0000);
    rd_chk("R13", 9'h02, 2'd0, 32'h0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 9'h0A0; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "rd_valid one cycle after", {31'b0, rd_valid}, 32'h1);
    check("R1", "rd_data one cycle after", rd_data, 32'h6515_0000);
    @(negedge clk);
    check("R1", "rd_valid idle", {31'b0, rd_valid}, 32'h0);
  endtask

  task automatic t_layout();
    wr(9'h04, 2'd2, 32'h1234_5678);
    rd_chk("R2", 9'h04, 2'd2, 32'h1234_5678);
    rd_chk("R14", 9'h06, 2'd0, 32'h34);
    wr(9'h05, 2'd0, 32'hFFFF_FFAB);
    rd_chk("R14", 9'h04, 2'd2, 32'h1234_AB78);
    wr(9'h0C, 2'd1, 32'hAAAA_F00D);
    rd_chk("R14", 9'h0C, 2'd2, 32'h0000_F00D);
    wr(9'h03, 2'd0, 32'h77);
    rd_chk("R2", 9'h03, 2'd0, 32'h0);
    wr(9'h050, 2'd2, 32'hDEAD_BEEF);
    rd_chk("R2", 9'h050, 2'd2, 32'h0);
    rd_chk("R2", 9'h00, 2'd2, 32'h0);
  endtask

  task automatic t_swdata();
    wr(9'h01, 2'd0, 32'hFF);
    rd_chk("R6", 9'h01, 2'd0, 32'h3F);
    wr(9'h19, 2'd0, 32'h2A);
    rd_chk("R3", 9'h09, 2'd0, 32'h2A);
  endtask

  task automatic t_alias();
    wr(9'h10, 2'd0, 32'h08);
    rd_chk("R3", 9'h00, 2'd0, 32'h08);
    wr(9'h18, 2'd0, 32'h09);
    rd_chk("R3", 9'h08, 2'd0, 32'h09);
    rd_chk("R13", 9'h0A, 2'd0, 32'h01);
  endtask

  task automatic t_status();
    wr(9'h02, 2'd0, 32'hE6);   // 7:3 stored, 2:1 clear from zero, 0 from command
    rd_chk("R13", 9'h02, 2'd0, 32'hE0);
    @(negedge clk); chan_irq_in = 2'b01;
    @(negedge clk);
    check("R11", "irq_out ch0", {31'b0, irq_out}, 32'h1);
    rd_chk("R13", 9'h02, 2'd0, 32'hE4);
    rd_chk("R10", 9'h0A0, 2'd2, 32'h6515_0800);
    rd_chk("R4", 9'h10, 2'd2, 32'h01E4_0018);
    wr(9'h12, 2'd0, 32'hE4);
    rd_chk("R13", 9'h02, 2'd0, 32'hE0);
    @(negedge clk); chan_irq_in = 2'b00;
    @(negedge clk);
    check("R11", "irq_out low", {31'b0, irq_out}, 32'h0);
    @(negedge clk); chan_irq_in = 2'b10;
    @(negedge clk);
    check("R11", "irq_out ch1", {31'b0, irq_out}, 32'h1);
    rd_chk("R4", 9'h10, 2'd2, 32'h05E0_4048);
    rd_chk("R5", 9'h18, 2'd2, 32'h0005_0019);
    rd_chk("R14", 9'h10, 2'd0, 32'h48);
    @(negedge clk); chan_irq_in = 2'b00;
    @(negedge clk);
    rd_chk("R10", 9'h0E0, 2'd2, 32'h6515_0000);
  endtask

  task automatic t_sctl();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h100; req_size = 2'd2; req_wdata = 32'hFFFF_F001;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R7", "bus_reset pulse", {30'b0, bus_reset}, 32'h1);
    @(negedge clk);
    check("R7", "bus_reset single", {30'b0, bus_reset}, 32'h0);
    rd_chk("R7", 9'h100, 2'd2, 32'h001);
    wr(9'h180, 2'd2, 32'h0000_0ABC);
    check("R7", "no pulse bit0 clear", {30'b0, bus_reset}, 32'h0);
    rd_chk("R7", 9'h180, 2'd2, 32'hABC);
    wr(9'h100, 2'd0, 32'h55);
    check("R7", "byte write no pulse", {30'b0, bus_reset}, 32'h0);
    rd_chk("R7", 9'h100, 2'd2, 32'h001);
  endtask

  task automatic t_ien();
    wr(9'h148, 2'd2, 32'hFFFF_1234);
    rd_chk("R8", 9'h148, 2'd2, 32'h3EED_0000);
    wr(9'h1C8, 2'd1, 32'hFFFF_FFFF);
    rd_chk("R8", 9'h1C8, 2'd2, 32'h0);
  endtask

  task automatic t_sstat();
    dev_present = 2'b01;
    rd_chk("R9", 9'h104, 2'd2, 32'h113);
    rd_chk("R9", 9'h184, 2'd2, 32'h0);
    dev_present = 2'b10;
    rd_chk("R9", 9'h104, 2'd2, 32'h0);
    rd_chk("R9", 9'h184, 2'd2, 32'h113);
  endtask

  task automatic t_taskfile();
    rd_chk("R12", 9'h082, 2'd0, 32'h02);
    rd_chk("R12", 9'h0CA, 2'd2, 32'hC0DE_001A);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h0C3; req_size = 2'd0; req_wdata = 32'h77;
    #1;
    check("R12", "tf_valid", {31'b0, tf_valid}, 32'h1);
    check("R12", "tf_write/chan/offset", {26'b0, tf_write, tf_chan, tf_offset}, {26'b0, 1'b1, 1'b1, 4'h3});
    check("R12", "tf_wdata", tf_wdata, 32'h77);
    check("R12", "tf_size", {30'b0, tf_size}, 32'h0);
    @(negedge clk);
    req_addr = 9'h088; req_write = 1'b0;
    #1;
    check("R12", "no forward at 0x88", {31'b0, tf_valid}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_layout();
    t_swdata();
    t_alias();
    t_status();
    t_sctl();
    t_ien();
    t_sstat();
    t_taskfile();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule